// File: doc/BRIEF.md
# Sigma-Delta Decimation Chain, 1-bit In, 16-bit Out

This block turns the single-bit stream of an oversampling sigma-delta modulator into 16-bit signed words. Its input runs at the sampling rate fs and its output runs at fs/128. The work is done by three stages in a fixed order. A third-order cascaded integrator-comb stage decimates by 32. A 7-tap symmetric shaping FIR then decimates by 2, and a 7-tap half-band FIR decimates by a further 2. Every stage marks its output samples with a one-cycle strobe.

All coefficients are constants in signed fixed point with ten fractional bits. Each FIR stage rounds its sum and saturates it to 16 bits before passing it on. A synchronous reset clears every integrator, comb delay and tap line. The output strobe stays low until every tap line along the chain holds samples taken after reset.

Top module: `sdm_decim_chain`

## Requirements
- R1: An input bit of 1 counts as +1 and a 0 counts as -1. After reset, all earlier history counts as 0.
- R2: CIC output k (k = 0, 1, ...) is the exact sum over j of h3[j]·x[32k+31-j]. Here h3 is the 94-point convolution of three 32-sample all-ones windows, and x[n] is the n-th mapped input after reset.
- R3: The shaping FIR uses the Q2.10 taps 1987, -195, -256, 0, -256, -195, 1987. It fires only on odd CIC outputs k = 2m+1, and its result m is sat16(round(sum_i c[i]·cic[2m+1-i] / 2^11)).
- R4: The half-band FIR uses the Q2.10 taps -64, 0, 320, 512, 320, 0, -64. It fires only on odd shaping outputs m = 2p+1, and its result p is sat16(round(sum_i c[i]·fir[2p+1-i] / 2^10)).
- R5: Rounding adds half an LSB and then floors. Saturation clamps to the range -32768..32767. A constant run of ones therefore yields 32767 on every flagged word, and a constant run of zeros yields -32768.
- R6: The valid strobe is high for one cycle per word. Word p appears after clock edge 128p+130, counted from the first edge after reset is released, so flagged words arrive exactly 128 clocks apart.
- R7: Words p = 0..4 have windows that reach back before reset, and these are not flagged. The first flagged word appears after edge 770.
- R8: While reset is high, the data output and the valid strobe are 0. A reset in the middle of a run restarts the chain exactly as from power-up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at fs |
| rst | input | 1 | Synchronous reset, active high |
| mod_bit | input | 1 | Modulator output bit, one per clock |
| pcm_data | output | 16 | Decimated signed sample |
| pcm_vld | output | 1 | One-cycle strobe marking a new sample |

## Verification
Output word p is due on a fixed clock edge, 128p+130 edges after reset is released. The bench counts the input bits it has driven and checks the outputs at each falling edge. When that count is 128p+130 and p is 5 or more, it expects the strobe together with the word. At any other count it expects the strobe to be low. The expected word comes from the bench's own model: a direct convolution of the recorded bit history through the three stages. It is compared only on the cycles the schedule marks.

// File: rtl/sdm_decim_pkg.sv
package sdm_decim_pkg;
  localparam int CIC_RATE  = 32;
  localparam int CIC_ORDER = 3;
  localparam int CIC_IN_W  = 2;
  localparam int CIC_W     = CIC_IN_W + CIC_ORDER * $clog2(CIC_RATE);
  localparam int PCM_W     = 16;
  localparam int COEF_W    = 12;
  localparam int COEF_FRAC = 10;
  localparam int TAPS      = 7;
  localparam int ACC_W     = 40;
  localparam int FIR_SHIFT = COEF_FRAC + 1;
  localparam int HB_SHIFT  = COEF_FRAC;

  typedef enum logic {KIND_SHAPE, KIND_HALF} fir_kind_e;

  function automatic int ceil_div(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // Outputs whose window reaches before reset, through all three stages
  function automatic int fill_outputs();
    int k0, m1;
    k0 = ceil_div((CIC_ORDER - 1) * (CIC_RATE - 1), CIC_RATE);
    m1 = ceil_div(k0 + TAPS - 2, 2);
    return ceil_div(m1 + TAPS - 2, 2);
  endfunction

  localparam int FILL       = fill_outputs();
  localparam int FIRST_EDGE = CIC_RATE * 4 * (FILL + 1) + 2;

  // Symmetric Q2.10 coefficient sets (R3, R4)
  function automatic logic signed [COEF_W-1:0] tap_coef(input fir_kind_e kind, input int idx);
    int j;
    j = (idx <= TAPS / 2) ? idx : TAPS - 1 - idx;
    if (kind == KIND_SHAPE) begin
      case (j)
        0:       return 12'sd1987;
        1:       return -12'sd195;
        2:       return -12'sd256;
        default: return 12'sd0;
      endcase
    end else begin
      case (j)
        0:       return -12'sd64;
        2:       return 12'sd320;
        3:       return 12'sd512;
        default: return 12'sd0;
      endcase
    end
  endfunction

  // Round half up, then clamp to the signed PCM range (R5)
  function automatic logic signed [PCM_W-1:0] round_sat(input logic signed [ACC_W-1:0] acc,
                                                        input int shift);
    logic signed [ACC_W-1:0] half, t, lim_hi, lim_lo;
    half = '0;
    half[shift-1] = 1'b1;
    t = (acc + half) >>> shift;
    lim_hi = ACC_W'(2 ** (PCM_W - 1) - 1);
    lim_lo = ACC_W'(-(2 ** (PCM_W - 1)));
    if (t > lim_hi) return {1'b0, {(PCM_W-1){1'b1}}};
    if (t < lim_lo) return {1'b1, {(PCM_W-1){1'b0}}};
    return t[PCM_W-1:0];
  endfunction
endpackage

// File: rtl/cic_decim.sv
module cic_decim
  import sdm_decim_pkg::*;
#(
  parameter int RATE  = CIC_RATE,
  parameter int ORDER = CIC_ORDER,
  parameter int W     = CIC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bit_in,
  output logic                out_vld,
  output logic signed [W-1:0] out_data
);
  localparam int PH_W = $clog2(RATE);

  logic [PH_W-1:0]     phase;
  logic                dump;
  logic signed [W-1:0] x;
  logic signed [W-1:0] integ [ORDER];
  logic signed [W-1:0] inext [ORDER];
  logic signed [W-1:0] cin   [ORDER+1];
  logic signed [W-1:0] cdly  [ORDER];

  // R1: bit to signed value
  assign x    = bit_in ? W'(1) : {W{1'b1}};
  assign dump = (phase == PH_W'(RATE - 1));

  generate
    for (genvar i = 0; i < ORDER; i++) begin : g_int
      if (i == 0) begin : g_first
        assign inext[i] = integ[i] + x;
      end else begin : g_rest
        assign inext[i] = integ[i] + inext[i-1];
      end
      always_ff @(posedge clk) begin
        if (rst) integ[i] <= '0;
        else     integ[i] <= inext[i];
      end
    end

    assign cin[0] = inext[ORDER-1];
    for (genvar i = 0; i < ORDER; i++) begin : g_comb
      assign cin[i+1] = cin[i] - cdly[i];
      always_ff @(posedge clk) begin
        if (rst)       cdly[i] <= '0;
        else if (dump) cdly[i] <= cin[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= '0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      phase   <= phase + 1'b1;
      out_vld <= dump;
      if (dump) out_data <= cin[ORDER];
    end
  end

  // R2: strobe is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
  // R2: wraparound arithmetic must land within the gain bound
  a_r2_no_overflow: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> (out_data <= W'(RATE ** ORDER) && out_data >= -W'(RATE ** ORDER)));
endmodule

// File: rtl/dec2_fir.sv
module dec2_fir
  import sdm_decim_pkg::*;
#(
  parameter fir_kind_e KIND  = KIND_SHAPE,
  parameter int        IN_W  = CIC_W,
  parameter int        SHIFT = FIR_SHIFT
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_vld,
  output logic signed [PCM_W-1:0] out_data
);
  localparam int HALF = TAPS / 2;

  logic                    phase;
  logic                    fire;
  logic signed [IN_W-1:0]  win  [TAPS];
  logic signed [IN_W-1:0]  dly  [TAPS-1];
  logic signed [ACC_W-1:0] prod [HALF+1];
  logic signed [ACC_W-1:0] acc;

  assign fire   = in_vld & phase;
  assign win[0] = in_data;

  generate
    for (genvar i = 1; i < TAPS; i++) begin : g_win
      assign win[i] = dly[i-1];
    end
    for (genvar i = 0; i < TAPS - 1; i++) begin : g_dly
      always_ff @(posedge clk) begin
        if (rst)         dly[i] <= '0;
        else if (in_vld) dly[i] <= win[i];
      end
    end
    // Pre-add mirrored taps; zero taps build no multiplier
    for (genvar i = 0; i < HALF; i++) begin : g_pair
      localparam logic signed [COEF_W-1:0] CF = tap_coef(KIND, i);
      if (CF != 0) begin : g_mul
        logic signed [IN_W:0] pre;
        assign pre     = IN_W'(win[i]) + IN_W'(win[TAPS-1-i]) + (IN_W+1)'(0);
        assign prod[i] = ACC_W'(pre) * ACC_W'(CF);
      end else begin : g_zero
        assign prod[i] = '0;
      end
    end
    if (tap_coef(KIND, HALF) != 0) begin : g_ctr
      assign prod[HALF] = ACC_W'(win[HALF]) * ACC_W'(tap_coef(KIND, HALF));
    end else begin : g_ctr0
      assign prod[HALF] = '0;
    end
  endgenerate

  always_comb begin
    acc = '0;
    for (int i = 0; i <= HALF; i++) acc = acc + prod[i];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= 1'b0;
      out_vld  <= 1'b0;
      out_data <= '0;
    end else begin
      if (in_vld) phase <= ~phase;
      out_vld <= fire;
      if (fire) out_data <= round_sat(acc, SHIFT);
    end
  end

  // R3 (shaping stage) and R4 (half-band stage): output only after an odd input
  a_r3_valid_follows_fire: assert property (@(posedge clk) disable iff (rst)
    out_vld |-> $past(in_vld) && $past(phase));
  // R3/R4: an even input never produces a result
  a_r4_even_input_silent: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !phase) |=> !out_vld);
  // R6: single-cycle strobe
  a_r6_fir_pulse: assert property (@(posedge clk) disable iff (rst)
    out_vld |=> !out_vld);
endmodule

// File: rtl/sdm_decim_chain.sv
module sdm_decim_chain
  import sdm_decim_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    mod_bit,
  output logic signed [PCM_W-1:0] pcm_data,
  output logic                    pcm_vld
);
  localparam int FILL_W = $clog2(FILL + 1);
  localparam int AGE_W  = $clog2(FIRST_EDGE + 2) + 1;

  logic                    cic_vld, fir_vld, hb_vld;
  logic signed [CIC_W-1:0] cic_data;
  logic signed [PCM_W-1:0] fir_data, hb_data;
  logic [FILL_W-1:0]       seen;
  logic                    primed;

  cic_decim #(.RATE(CIC_RATE), .ORDER(CIC_ORDER), .W(CIC_W)) u_cic (
    .clk(clk), .rst(rst), .bit_in(mod_bit),
    .out_vld(cic_vld), .out_data(cic_data));

  dec2_fir #(.KIND(KIND_SHAPE), .IN_W(CIC_W), .SHIFT(FIR_SHIFT)) u_shape (
    .clk(clk), .rst(rst), .in_vld(cic_vld), .in_data(cic_data),
    .out_vld(fir_vld), .out_data(fir_data));

  dec2_fir #(.KIND(KIND_HALF), .IN_W(PCM_W), .SHIFT(HB_SHIFT)) u_half (
    .clk(clk), .rst(rst), .in_vld(fir_vld), .in_data(fir_data),
    .out_vld(hb_vld), .out_data(hb_data));

  // R7: hold the strobe back until every tap line holds post-reset data
  assign primed = (seen == FILL_W'(FILL));
  always_ff @(posedge clk) begin
    if (rst)                   seen <= '0;
    else if (hb_vld && !primed) seen <= seen + 1'b1;
  end

  assign pcm_data = hb_data;
  assign pcm_vld  = hb_vld & primed;

  // Observation counters for the assertions below
  logic [7:0]       gap;
  logic             have_prev;
  logic [AGE_W-1:0] age;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap       <= '0;
      have_prev <= 1'b0;
      age       <= '0;
    end else begin
      if (pcm_vld)             gap <= '0;
      else if (gap != 8'hff)   gap <= gap + 1'b1;
      if (pcm_vld) have_prev <= 1'b1;
      if (age != {AGE_W{1'b1}}) age <= age + 1'b1;
    end
  end

  // R6: flagged words are exactly 128 clocks apart
  a_r6_spacing: assert property (@(posedge clk) disable iff (rst)
    (pcm_vld && have_prev) |-> gap == 8'(4 * CIC_RATE - 1));
  // R7: nothing flagged before the first full window
  a_r7_not_early: assert property (@(posedge clk) disable iff (rst)
    pcm_vld |-> age >= AGE_W'(FIRST_EDGE));
  // R8: reset leaves the outputs quiet
  a_r8_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (!pcm_vld && pcm_data == '0));
endmodule

// File: tb/sim_sdm_decim_chain.sv
`timescale 1ns/1ps
module sim_sdm_decim_chain;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mod_bit = 1'b0;
  logic signed [15:0] pcm_data;
  logic        pcm_vld;

  int n_cmp = 0, n_bad = 0;
  bit xs [0:4095];
  int ns;
  int h3 [0:93];
  int fc [0:6];
  int hc [0:6];
  int blk;
  bit done = 1'b0;

  always #4 clk = ~clk;

  sdm_decim_chain u0 (.clk(clk), .rst(rst), .mod_bit(mod_bit),
                      .pcm_data(pcm_data), .pcm_vld(pcm_vld));

  function automatic int q10(input real r);
    return int'($floor(r * 1024.0 + 0.5));
  endfunction

  function automatic int rs16(input longint acc, input int sh);
    longint d, q, f;
    d = 64'sd1 <<< sh;
    q = acc + (d / 2);
    f = (q >= 0) ? q / d : -((-q + d - 1) / d);
    if (f > 32767) f = 32767;
    if (f < -32768) f = -32768;
    return int'(f);
  endfunction

  function automatic int cic_ref(input int k);
    longint s = 0;
    for (int j = 0; j < 94; j++) begin
      int n = 32 * k + 31 - j;
      if (n >= 0) s += h3[j] * (xs[n] ? 1 : -1);
    end
    return int'(s);
  endfunction

  function automatic int fir_ref(input int m);
    longint s = 0;
    for (int i = 0; i < 7; i++) begin
      int k = 2 * m + 1 - i;
      if (k >= 0) s += longint'(fc[i]) * cic_ref(k);
    end
    return rs16(s, 11);
  endfunction

  function automatic int hb_ref(input int p);
    longint s = 0;
    for (int i = 0; i < 7; i++) begin
      int m = 2 * p + 1 - i;
      if (m >= 0) s += longint'(hc[i]) * fir_ref(m);
    end
    return rs16(s, 10);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d (samples=%0d)", tag, act, exp, ns);
    end
  endtask

  function automatic bit gen(input int mode);
    case (mode)
      1: return 1'b1;
      2: return 1'b0;
      3: return ($urandom % 100) < 80;
      4: begin
        if (ns % 32 == 0) blk = $urandom % 2;
        return blk[0];
      end
      default: return $urandom % 2;
    endcase
  endfunction

  task automatic run_segment(input int mode, input int outs);
    int last_ns;
    bit got_first;
    got_first = 1'b0;
    last_ns = 128 * (5 + outs) + 131;
    @(negedge clk);
    rst = 1'b1;
    mod_bit = 1'b0;
    repeat (3) begin
      @(negedge clk);
      check(pcm_vld == 1'b0, "R8 valid in reset", pcm_vld, 0);
      check(pcm_data == 16'sd0, "R8 data in reset", pcm_data, 0);
    end
    ns = 0;
    rst = 1'b0;
    xs[0] = gen(mode);
    mod_bit = xs[0];
    ns = 1;
    while (ns < last_ns) begin
      bit exp_v;
      @(negedge clk);
      exp_v = (ns >= 770) && ((ns - 130) % 128 == 0);
      if (exp_v || pcm_vld)
        check(pcm_vld == exp_v, "R6 strobe schedule", pcm_vld, exp_v);
      if (pcm_vld && !got_first) begin
        got_first = 1'b1;
        check(ns == 770, "R7 first flagged edge", ns, 770);
      end
      if (pcm_vld && exp_v) begin
        int p = (ns - 130) / 128;
        int e = hb_ref(p);
        check(int'(pcm_data) == e, "R1 R2 R3 R4 word", pcm_data, e);
        if (mode == 1) check(pcm_data == 16'sd32767, "R5 clamp high", pcm_data, 32767);
        if (mode == 2) check(pcm_data == -16'sd32768, "R5 clamp low", pcm_data, -32768);
      end
      xs[ns] = gen(mode);
      mod_bit = xs[ns];
      ns++;
    end
  endtask

  initial begin
    int seed_sink;
    real fr [0:3];
    real hr [0:3];
    seed_sink = $urandom(20240611);
    fr[0] = 1.94; fr[1] = -0.19; fr[2] = -0.25; fr[3] = 0.0;
    hr[0] = -0.0625; hr[1] = 0.0; hr[2] = 0.3125; hr[3] = 0.5;
    for (int i = 0; i < 7; i++) begin
      fc[i] = q10(fr[(i <= 3) ? i : 6 - i]);
      hc[i] = q10(hr[(i <= 3) ? i : 6 - i]);
    end
    for (int j = 0; j < 94; j++) h3[j] = 0;
    for (int a = 0; a < 32; a++)
      for (int b = 0; b < 32; b++)
        for (int c = 0; c < 32; c++)
          h3[a + b + c]++;
    blk = 0;
    ns = 0;
    run_segment(0, 12);   // balanced random bits
    run_segment(1, 4);    // constant ones, reset arrives mid-stream
    run_segment(2, 4);    // constant zeros
    run_segment(3, 6);    // dense random bits
    run_segment(4, 8);    // random 32-bit blocks
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule